// File: doc/BRIEF.md
# Row Hit Timestamp Logger

This block collects binary hits from one row of 36 pixel comparators during a beam train. Each pixel supplies only a hit or no-hit bit, with no amplitude. While an acquisition window is open, the row's hit flags are sampled once on each beam crossing strobe. Pixels set in a mask register are removed, so noisy channels can be silenced. Every remaining hit becomes one record. A record holds the 6-bit pixel address and the 13-bit timestamp of the crossing, and it is stored in local memory.

Records are never sent out while the train runs. After the window closes, a valid/ready port returns the stored records in the order they were written. It then sends one end-of-data marker that carries the record count and a sticky loss flag. Once the marker is accepted, the memory is empty and the flag is clear, ready for the next train. The mask can be changed only between trains.

Top module: `row_hit_logger`

## Requirements
- R1: After reset, rd_valid and overflow are 0 and the block is idle.
- R2: A mask_we pulse while idle loads mask_din, where bit i masks pixel i. A mask_we pulse during a train or during readout is ignored, and the mask in use is unchanged.
- R3: A pixel whose mask bit is 1 never produces a record.
- R4: A record has the pixel address in rd_data[18:13] and the timestamp in rd_data[12:0]. The timestamp is the number of crossings seen earlier in the same train, so the first crossing after train_start is stamped 0.
- R5: When several unmasked pixels hit in one crossing, one record is written per clock, in ascending address order.
- R6: The timestamp saturates at 8191 and does not wrap.
- R7: With DEPTH records stored, each further hit is discarded and sets overflow. Records already stored are kept unchanged.
- R8: If a new crossing arrives before all hits of the previous crossing are written, the unwritten hits are dropped and overflow is set.
- R9: After train_end, records are presented in write order. While rd_valid is 1 and rd_ready is 0, rd_data and rd_last hold steady.
- R10: After the last record, the port shows a marker with rd_last = 1, the overflow flag in rd_data[18], and the record count in rd_data[4:0].
- R11: Acceptance of the marker clears the record count and overflow and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| train_start | input | 1 | Opens the acquisition window (accepted when idle) |
| train_end | input | 1 | Closes the window and starts readout |
| xing | input | 1 | Beam crossing strobe, samples hits |
| hits | input | 36 | Binary hit flags of the row |
| mask_we | input | 1 | Mask load strobe |
| mask_din | input | 36 | New mask value, 1 = pixel excluded |
| rd_ready | input | 1 | Consumer ready |
| rd_valid | output | 1 | Record or marker present |
| rd_data | output | 19 | Record {address, timestamp} or marker {overflow, count} |
| rd_last | output | 1 | Current word is the end-of-data marker |
| overflow | output | 1 | Sticky loss flag for the current train |

## Verification
The assertions check the following on every cycle: the mask does not change outside idle, no write targets a masked pixel, the encoder grants are one-hot with rising addresses inside a crossing, the timestamp never decreases, the fill level stays bounded, the loss flag is sticky, readout data holds under stall, and the store is cleared after the marker. Only the bench scenarios can show that the right records appear with the right stamps and in the right order. They also show that a full memory keeps its oldest records, that a crossing arriving too soon drops exactly the unwritten hits, that the timestamp saturates after more than 8191 crossings, and that the marker reports the true count.

// File: rtl/rhl_pkg.sv
package rhl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_READ = 2'd2
  } rhl_state_e;
endpackage

// File: rtl/rhl_ts_counter.sv
module rhl_ts_counter #(
  parameter int TS_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            step,
  output logic [TS_W-1:0] ts
);
  localparam logic [TS_W-1:0] TS_MAX = '1;

  function automatic logic [TS_W-1:0] sat_inc(input logic [TS_W-1:0] v);
    return (v == TS_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ts <= '0;
    else if (clear) ts <= '0;
    else if (step)  ts <= sat_inc(ts);
  end
endmodule

// File: rtl/rhl_prio_enc.sv
module rhl_prio_enc #(
  parameter int N  = 36,
  parameter int AW = 6
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [AW-1:0] idx,
  output logic [N-1:0]  grant
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = AW'(i);
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_grant
      assign grant[g] = found && (idx == AW'(g));
    end
  endgenerate
endmodule

// File: rtl/rhl_rec_store.sv
module rhl_rec_store #(
  parameter int REC_W = 19,
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_req,
  input  logic [REC_W-1:0] wr_rec,
  input  logic [CNT_W-1:0] rd_idx,
  output logic             wr_fire,
  output logic             full,
  output logic [CNT_W-1:0] count,
  output logic [REC_W-1:0] rd_rec
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [REC_W-1:0] mem [DEPTH];

  assign full    = (count == CNT_W'(DEPTH));
  assign wr_fire = wr_req && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (wr_fire) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[count[PTR_W-1:0]] <= wr_rec;
  end

  assign rd_rec = (rd_idx < CNT_W'(DEPTH)) ? mem[rd_idx[PTR_W-1:0]] : '0;
endmodule

// File: rtl/row_hit_logger.sv
module row_hit_logger
  import rhl_pkg::*;
#(
  parameter int NUM_PIX = 36,
  parameter int TS_W    = 13,
  parameter int DEPTH   = 16,
  localparam int ADDR_W = $clog2(NUM_PIX),
  localparam int REC_W  = ADDR_W + TS_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               train_start,
  input  logic               train_end,
  input  logic               xing,
  input  logic [NUM_PIX-1:0] hits,
  input  logic               mask_we,
  input  logic [NUM_PIX-1:0] mask_din,
  input  logic               rd_ready,
  output logic               rd_valid,
  output logic [REC_W-1:0]   rd_data,
  output logic               rd_last,
  output logic               overflow
);
  function automatic logic [REC_W-1:0] pack_rec(input logic [ADDR_W-1:0] a,
                                                input logic [TS_W-1:0] t);
    return {a, t};
  endfunction

  function automatic logic [REC_W-1:0] pack_marker(input logic ovf,
                                                   input logic [CNT_W-1:0] n);
    logic [REC_W-1:0] m;
    m = '0;
    m[REC_W-1]   = ovf;
    m[CNT_W-1:0] = n;
    return m;
  endfunction

  rhl_state_e         state_q;
  logic [NUM_PIX-1:0] mask_q;
  logic [NUM_PIX-1:0] pend_q;
  logic [TS_W-1:0]    pend_ts_q;
  logic [CNT_W-1:0]   rd_ptr_q;
  logic               ovf_q;

  // Named internal events
  logic               idle, acq;
  logic               start_evt, end_evt, xing_evt, mask_load;
  logic               enc_found;
  logic [ADDR_W-1:0]  enc_idx;
  logic [NUM_PIX-1:0] enc_grant;
  logic               wr_req, wr_fire, store_full;
  logic               drop_full, drop_late;
  logic               rd_fire, rd_done;
  logic [CNT_W-1:0]   count;
  logic [REC_W-1:0]   rd_rec;
  logic [TS_W-1:0]    ts;

  assign idle      = (state_q == ST_IDLE);
  assign acq       = (state_q == ST_ACQ);
  assign start_evt = idle && train_start;
  assign end_evt   = acq && train_end;
  assign xing_evt  = acq && xing;
  assign mask_load = idle && mask_we;
  assign wr_req    = acq && !xing && enc_found;
  assign drop_full = wr_req && store_full;
  assign drop_late = (xing_evt || end_evt) && (pend_q != '0);

  rhl_ts_counter #(.TS_W(TS_W)) u_ts (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_evt),
    .step  (xing_evt),
    .ts    (ts)
  );

  rhl_prio_enc #(.N(NUM_PIX), .AW(ADDR_W)) u_enc (
    .req   (pend_q),
    .found (enc_found),
    .idx   (enc_idx),
    .grant (enc_grant)
  );

  rhl_rec_store #(.REC_W(REC_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (rd_done),
    .wr_req  (wr_req),
    .wr_rec  (pack_rec(enc_idx, pend_ts_q)),
    .rd_idx  (rd_ptr_q),
    .wr_fire (wr_fire),
    .full    (store_full),
    .count   (count),
    .rd_rec  (rd_rec)
  );

  // Readout port
  assign rd_valid = (state_q == ST_READ);
  assign rd_last  = rd_valid && (rd_ptr_q == count);
  assign rd_data  = rd_last ? pack_marker(ovf_q, count) : rd_rec;
  assign rd_fire  = rd_valid && rd_ready;
  assign rd_done  = rd_fire && rd_last;
  assign overflow = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_evt) state_q <= ST_ACQ;
        ST_ACQ:  if (end_evt)   state_q <= ST_READ;
        ST_READ: if (rd_done)   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_load) mask_q <= mask_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      pend_ts_q <= '0;
    end else if (start_evt || end_evt) begin
      pend_q    <= '0;
    end else if (xing_evt) begin
      pend_q    <= hits & ~mask_q;
      pend_ts_q <= ts;
    end else if (wr_req) begin
      pend_q    <= pend_q & ~enc_grant;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ovf_q <= 1'b0;
    else if (rd_done)                ovf_q <= 1'b0;
    else if (drop_full || drop_late) ovf_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rd_ptr_q <= '0;
    else if (rd_done)           rd_ptr_q <= '0;
    else if (rd_fire)           rd_ptr_q <= rd_ptr_q + 1'b1;
  end
endmodule

// File: rtl/rhl_chk.sv
module rhl_chk #(
  parameter int NUM_PIX = 36,
  parameter int TS_W    = 13,
  parameter int DEPTH   = 16,
  parameter int ADDR_W  = 6,
  parameter int REC_W   = 19,
  parameter int CNT_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               idle,
  input logic               start_evt,
  input logic               xing_evt,
  input logic [NUM_PIX-1:0] mask_q,
  input logic               wr_req,
  input logic               wr_fire,
  input logic [ADDR_W-1:0]  enc_idx,
  input logic [NUM_PIX-1:0] enc_grant,
  input logic [TS_W-1:0]    ts,
  input logic [CNT_W-1:0]   count,
  input logic               overflow,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic               rd_last,
  input logic [REC_W-1:0]   rd_data,
  input logic               rd_done
);
  // R2
  a_r2_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(mask_q));
  // R3
  a_r3_no_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !mask_q[enc_idx]);
  // R5
  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(enc_grant));
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && $past(wr_req) && !$past(xing_evt) |-> enc_idx > $past(enc_idx));
  // R6
  a_r6_ts_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> ts >= $past(ts));
  // R7
  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !rd_done |=> overflow);
  // R9
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_last));
  // R11
  a_r11_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> count == '0 && !overflow && !rd_valid);
endmodule

bind row_hit_logger rhl_chk #(
  .NUM_PIX(NUM_PIX), .TS_W(TS_W), .DEPTH(DEPTH),
  .ADDR_W(ADDR_W), .REC_W(REC_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idle      (idle),
  .start_evt (start_evt),
  .xing_evt  (xing_evt),
  .mask_q    (mask_q),
  .wr_req    (wr_req),
  .wr_fire   (wr_fire),
  .enc_idx   (enc_idx),
  .enc_grant (enc_grant),
  .ts        (ts),
  .count     (count),
  .overflow  (overflow),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_last   (rd_last),
  .rd_data   (rd_data),
  .rd_done   (rd_done)
);

// File: tb/row_hit_logger_tb_top.sv
module row_hit_logger_tb_top;
  localparam int NP    = 36;
  localparam int TW    = 13;
  localparam int DEPTH = 16;
  localparam int RW    = 19;
  localparam int TS_MAX = 8191;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic train_start = 0, train_end = 0, xing = 0, mask_we = 0, rd_ready = 0;
  logic [NP-1:0] hits = '0, mask_din = '0;
  logic rd_valid, rd_last, overflow;
  logic [RW-1:0] rd_data;

  always #10 clk = ~clk;

  row_hit_logger dut_i (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_end(train_end),
    .xing(xing), .hits(hits), .mask_we(mask_we), .mask_din(mask_din),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .overflow(overflow)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // Bench model
  logic [NP-1:0] bmask = '0;
  int exp_addr [64];
  int exp_ts [64];
  int n_exp = 0;
  bit exp_ovf = 0;
  int bts = 0;

  // Stimulus table for the first train: hit patterns, one per crossing
  localparam logic [NP-1:0] VEC [6] = '{
    36'h0_0000_0000,
    36'h8_0000_0001,
    36'h0_0000_0060,
    36'h0_0012_0008,
    36'h0_0000_000F,
    36'h8_0000_0000
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    n_exp = 0; exp_ovf = 0; bts = 0;
  endtask

  task automatic model_xing(input logic [NP-1:0] h);
    for (int i = 0; i < NP; i++) begin
      if (h[i] && !bmask[i]) begin
        if (n_exp < DEPTH) begin
          exp_addr[n_exp] = i; exp_ts[n_exp] = bts; n_exp++;
        end else exp_ovf = 1;
      end
    end
    bts = (bts < TS_MAX) ? bts + 1 : TS_MAX;
  endtask

  task automatic pulse_start();
    @(negedge clk) train_start = 1;
    @(negedge clk) train_start = 0;
  endtask

  task automatic pulse_end();
    @(negedge clk) train_end = 1;
    @(negedge clk) train_end = 0;
  endtask

  task automatic do_xing(input logic [NP-1:0] h);
    @(negedge clk) begin hits = h; xing = 1; end
    @(negedge clk) begin xing = 0; hits = '0; end
  endtask

  task automatic load_mask(input logic [NP-1:0] m);
    @(negedge clk) begin mask_din = m; mask_we = 1; end
    @(negedge clk) mask_we = 0;
  endtask

  // Drain all records and compare with the model; stall_first holds ready low first
  task automatic drain(input string req, input bit stall_first);
    logic [RW-1:0] held;
    int k = 0;
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      if (!rd_valid) begin
        check(0, {req, " valid"}, 0, 1);
        done = 1;
      end else begin
        if (stall_first && k == 0) begin
          held = rd_data;
          repeat (3) @(negedge clk);
          check(rd_valid && rd_data == held, "R9 stall hold", rd_data, held);
        end
        if (rd_last) begin
          check(k == n_exp, {req, " R10 marker position"}, k, n_exp);
          check(rd_data[4:0] == 5'(n_exp), "R10 marker count", rd_data[4:0], n_exp);
          check(rd_data[RW-1] == exp_ovf, "R10 marker overflow", rd_data[RW-1], exp_ovf);
          done = 1;
        end else if (k < n_exp) begin
          check(rd_data == RW'((exp_addr[k] << TW) | exp_ts[k]), {req, " R4 R9 record"},
                rd_data, (exp_addr[k] << TW) | exp_ts[k]);
        end else begin
          check(0, {req, " extra record"}, rd_data, 0);
        end
        k++;
        rd_ready = 1;
        @(negedge clk) rd_ready = 0;
      end
    end
    check(!rd_valid && !overflow, "R11 idle and cleared", {rd_valid, overflow}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rd_valid && !overflow, "R1 reset state", {rd_valid, overflow}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!rd_valid && !overflow, "R1 after release", {rd_valid, overflow}, 0);

    // Train A: table of crossings, pixels 5 and 20 masked (R2, R3, R4, R5)
    bmask = (36'h1 << 5) | (36'h1 << 20);
    load_mask(bmask);
    model_reset();
    pulse_start();
    for (int v = 0; v < 6; v++) begin
      if (v == 2) load_mask('0);      // R2: ignored during the train
      do_xing(VEC[v]);
      model_xing(VEC[v]);
      repeat (NP + 4) @(negedge clk);
    end
    pulse_end();
    drain("R3 R5 train A", 0);

    // R2: mask write during readout is ignored too; mask load ignored check via next train
    // Train B: fill beyond DEPTH (R7), with stall on first word (R9)
    model_reset();
    pulse_start();
    for (int v = 0; v < 3; v++) begin
      do_xing(36'h0_0000_00FF);
      model_xing(36'h0_0000_00FF);
      repeat (NP + 4) @(negedge clk);
    end
    check(overflow, "R7 overflow set", overflow, 1);
    pulse_end();
    drain("R7 train B", 1);

    // Train C: crossing too early drops unwritten hits (R8)
    model_reset();
    pulse_start();
    do_xing(36'h0_0000_00FF);
    do_xing(36'h0_0000_0002);
    repeat (NP + 4) @(negedge clk);
    n_exp = 2; exp_ovf = 1;
    exp_addr[0] = 0; exp_ts[0] = 0;
    exp_addr[1] = 1; exp_ts[1] = 1;
    check(overflow, "R8 overflow on early crossing", overflow, 1);
    pulse_end();
    drain("R8 train C", 0);

    // Train D: timestamp saturation (R6), flags cleared from before (R11)
    model_reset();
    pulse_start();
    check(!overflow, "R11 new train clean", overflow, 0);
    @(negedge clk) xing = 1;
    repeat (8195) @(negedge clk);
    xing = 0;
    for (int i = 0; i < 8195; i++) model_xing('0);
    do_xing(36'h0_0000_0400);
    model_xing(36'h0_0000_0400);
    repeat (NP + 4) @(negedge clk);
    check(exp_ts[0] == TS_MAX, "R6 model saturates", exp_ts[0], TS_MAX);
    pulse_end();
    drain("R6 train D", 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule